// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block builds the drive signal for an infrared emitter. It takes two carrier waves from timers and a serial transmit data line. It combines them under a five-bit control word. In amplitude-shift keying (ASK) the data bit gates carrier A against a fixed idle level. In frequency-shift keying (FSK) the data bit picks carrier A or carrier B. The modulating data comes from either the serial line or a data bit that software writes into the control word. A polarity bit inverts the modulated result. When the enable bit is clear, the serial line goes straight to the emitter pin.

The modulating data passes through `SYNC_STAGES` flops and then into a small state register. A data or mode change therefore lands on a clock edge, never partway through the logic. The carriers themselves pass from the selected input to the pin with no register.

The state register holds five named states:
- `S_PASS`: serial line to the pin.
- `S_ASK_ON`: carrier A.
- `S_ASK_OFF`: idle level.
- `S_FSK_A`: carrier A.
- `S_FSK_B`: carrier B.

Every clock edge computes the next state from scratch. If enable is clear, the next state is `S_PASS`. If enable is set in ASK mode, the next state is `S_ASK_ON` for data 1 and `S_ASK_OFF` for data 0. If enable is set in FSK mode, the next state is `S_FSK_A` for data 1 and `S_FSK_B` for data 0. Any state can move to any other state in one edge.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset, every control bit reads 0, the state is `S_PASS`, and `ir_out` equals `tx_in`.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` on the next clock edge. `cfg_rdata` always returns the five bits: bit 0 enable, bit 1 invert, bit 2 FSK mode (1) or ASK mode (0), bit 3 data source (1 selects software data, 0 selects `tx_in`), bit 4 software data. Without a write, the value holds.
- R3: While disabled (`S_PASS`), `ir_out` follows `tx_in` combinationally with no inversion. The carriers and the invert bit have no effect.
- R4: Enabled in ASK mode with data 1, `ir_out` is `carrier_a` (XOR invert).
- R5: Enabled in ASK mode with data 0, `ir_out` is the parameter `IDLE_LEVEL` (XOR invert).
- R6: Enabled in FSK mode, `ir_out` is `carrier_a` for data 1 and `carrier_b` for data 0 (XOR invert).
- R7: When enabled, the invert bit inverts the modulated output. This takes effect one clock edge after the write.
- R8: With the data source bit set, the software data bit is the modulating data and `tx_in` has no effect on `ir_out`.
- R9: A change on `tx_in` used as modulating data reaches `ir_out` on the `SYNC_STAGES+1`-th rising edge after it, not earlier.
- R10: A write that changes enable or mode shows on `ir_out` at the second rising edge after the write cycle, not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 5 | Control word write value |
| cfg_rdata | output | 5 | Current control word |
| carrier_a | input | 1 | Carrier from the first timer (mark) |
| carrier_b | input | 1 | Carrier from the second timer (FSK space) |
| tx_in | input | 1 | Serial transmit data line |
| ir_out | output | 1 | Modulated emitter drive |

## Verification
The bench builds the block with `SYNC_STAGES=2` and `IDLE_LEVEL=1`. With these values a one-stage data path and a hard-wired low idle level both give wrong outputs. The bench covers all 32 control words, both `tx_in` levels and all four carrier combinations. Each combination is compared with a model computed from the requirements. Separate edge-by-edge checks confirm the data and control latencies. Because there are two sync stages, those checks can detect a pipeline that is one stage too short.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;
    localparam int CFG_W   = 5;
    localparam int B_EN    = 0;
    localparam int B_INV   = 1;
    localparam int B_FSK   = 2;
    localparam int B_SWSRC = 3;
    localparam int B_SWBIT = 4;

    typedef struct packed {
        logic sw_bit;
        logic sw_src;
        logic fsk;
        logic inv;
        logic en;
    } ir_cfg_t;

    typedef enum logic [2:0] {
        S_PASS    = 3'd0,
        S_ASK_ON  = 3'd1,
        S_ASK_OFF = 3'd2,
        S_FSK_A   = 3'd3,
        S_FSK_B   = 3'd4
    } mod_state_e;
endpackage

// File: rtl/ir_cfg_reg.sv
module ir_cfg_reg
    import ir_mod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output ir_cfg_t          cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= ir_cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/ir_data_sync.sv
module ir_data_sync #(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_sw,
    input  logic sw_bit,
    input  logic tx_in,
    output logic data_q
);
    logic                   src;
    logic [SYNC_STAGES-1:0] chain;

    assign src = use_sw ? sw_bit : tx_in;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= src;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign data_q = chain[SYNC_STAGES-1];
endmodule

// File: rtl/ir_mod_fsm.sv
module ir_mod_fsm
    import ir_mod_pkg::*;
#(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ir_cfg_t    cfg,
    input  logic       data_q,
    input  logic       carrier_a,
    input  logic       carrier_b,
    input  logic       tx_in,
    output mod_state_e state,
    output logic       ir_out
);
    mod_state_e next_state;

    always_comb begin
        if (!cfg.en)      next_state = S_PASS;
        else if (cfg.fsk) next_state = data_q ? S_FSK_A : S_FSK_B;
        else              next_state = data_q ? S_ASK_ON : S_ASK_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_PASS;
        else        state <= next_state;
    end

    always_comb begin
        unique case (state)
            S_PASS:    ir_out = tx_in;
            S_ASK_ON:  ir_out = carrier_a ^ cfg.inv;
            S_ASK_OFF: ir_out = IDLE_LEVEL ^ cfg.inv;
            S_FSK_A:   ir_out = carrier_a ^ cfg.inv;
            S_FSK_B:   ir_out = carrier_b ^ cfg.inv;
            default:   ir_out = tx_in;
        endcase
    end
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
    import ir_mod_pkg::*;
#(
    parameter int SYNC_STAGES = 1,
    parameter bit IDLE_LEVEL  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             carrier_a,
    input  logic             carrier_b,
    input  logic             tx_in,
    output logic             ir_out
);
    ir_cfg_t    cfg;
    logic       data_q;
    mod_state_e mod_state;

    ir_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    ir_data_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .use_sw (cfg.sw_src),
        .sw_bit (cfg.sw_bit),
        .tx_in  (tx_in),
        .data_q (data_q)
    );

    ir_mod_fsm #(.IDLE_LEVEL(IDLE_LEVEL)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .data_q    (data_q),
        .carrier_a (carrier_a),
        .carrier_b (carrier_b),
        .tx_in     (tx_in),
        .state     (mod_state),
        .ir_out    (ir_out)
    );

    assign cfg_rdata = CFG_W'(cfg);
endmodule

// File: rtl/ir_carrier_mod_chk.sv
module ir_carrier_mod_chk
    import ir_mod_pkg::*;
#(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             carrier_a,
    input logic             carrier_b,
    input logic             tx_in,
    input logic             ir_out,
    input mod_state_e       state
);
    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));
    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));
    // R3
    pass_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[B_EN] |=> state == S_PASS);
    // R3
    pass_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_PASS |-> ir_out == tx_in);
    // R4
    mark_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ASK_ON || state == S_FSK_A) |-> ir_out == (carrier_a ^ cfg_rdata[B_INV]));
    // R5
    ask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_ASK_OFF |-> ir_out == (IDLE_LEVEL ^ cfg_rdata[B_INV]));
    // R6
    fsk_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FSK_B |-> ir_out == (carrier_b ^ cfg_rdata[B_INV]));
    // R10
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[B_EN] && cfg_rdata[B_FSK]) |=> (state == S_FSK_A || state == S_FSK_B));
endmodule

bind ir_carrier_mod ir_carrier_mod_chk #(.IDLE_LEVEL(IDLE_LEVEL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .carrier_a (carrier_a),
    .carrier_b (carrier_b),
    .tx_in     (tx_in),
    .ir_out    (ir_out),
    .state     (mod_state)
);

// File: tb/ir_carrier_mod_bench.sv
module ir_carrier_mod_bench;
    localparam int TB_SYNC = 2;
    localparam bit TB_IDLE = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [4:0] cfg_rdata;
    logic       carrier_a = 1'b0;
    logic       carrier_b = 1'b0;
    logic       tx_in = 1'b0;
    logic       ir_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ir_carrier_mod #(.SYNC_STAGES(TB_SYNC), .IDLE_LEVEL(TB_IDLE)) u_ir_carrier_mod (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .carrier_a (carrier_a),
        .carrier_b (carrier_b),
        .tx_in     (tx_in),
        .ir_out    (ir_out)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [4:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic model(input logic [4:0] c, input logic t, input logic a, input logic b);
        logic d, v;
        if (!c[0]) return t;
        d = c[3] ? c[4] : t;
        v = c[2] ? (d ? a : b) : (d ? a : TB_IDLE);
        return v ^ c[1];
    endfunction

    function automatic string tag(input logic [4:0] c, input logic t);
        logic d;
        d = c[3] ? c[4] : t;
        if (!c[0]) return "R3";
        if (c[1])  return "R7";
        if (c[3])  return "R8";
        if (c[2])  return "R6";
        if (d)     return "R4";
        return "R5";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", cfg_rdata, 5'd0);
        tx_in = 1'b1; #1;
        chk("R1", {4'd0, ir_out}, 5'd1);
        tx_in = 1'b0; #1;
        chk("R1", {4'd0, ir_out}, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep over all control words, data levels and carrier pairs
        for (int c = 0; c < 32; c++) begin
            for (int t = 0; t < 2; t++) begin
                tx_in = t[0];
                write_cfg(c[4:0]);
                repeat (5) @(negedge clk);
                // R2: readback of the full word
                chk("R2", cfg_rdata, c[4:0]);
                for (int ab = 0; ab < 4; ab++) begin
                    carrier_a = ab[0];
                    carrier_b = ab[1];
                    #1;
                    chk(tag(c[4:0], t[0]), {4'd0, ir_out},
                        {4'd0, model(c[4:0], t[0], ab[0], ab[1])});
                end
            end
        end

        // R3: passthrough is combinational
        write_cfg(5'b00110);
        repeat (4) @(negedge clk);
        tx_in = 1'b1; #1;
        chk("R3", {4'd0, ir_out}, 5'd1);
        tx_in = 1'b0; #1;
        chk("R3", {4'd0, ir_out}, 5'd0);

        // R8: with software data, tx_in is ignored
        carrier_a = 1'b0;
        write_cfg(5'b11001);
        repeat (5) @(negedge clk);
        tx_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8", {4'd0, ir_out}, 5'd0);

        // R9: data latency of SYNC_STAGES+1 edges
        carrier_a = 1'b0;
        tx_in = 1'b1;
        write_cfg(5'b00001);
        repeat (5) @(negedge clk);
        chk("R9", {4'd0, ir_out}, 5'd0);
        tx_in = 1'b0;
        @(negedge clk);
        chk("R9", {4'd0, ir_out}, 5'd0);
        @(negedge clk);
        chk("R9", {4'd0, ir_out}, 5'd0);
        @(negedge clk);
        chk("R9", {4'd0, ir_out}, {4'd0, TB_IDLE});

        // R10: mode change lands on the second edge
        carrier_b = 1'b0;
        write_cfg(5'b00101);
        chk("R10", {4'd0, ir_out}, {4'd0, TB_IDLE});
        @(negedge clk);
        chk("R10", {4'd0, ir_out}, 5'd0);

        // R7: polarity lands on the first edge
        write_cfg(5'b00001);
        repeat (2) @(negedge clk);
        write_cfg(5'b00011);
        chk("R7", {4'd0, ir_out}, {4'd0, ~TB_IDLE});

        finish_run();
    end
endmodule